// File: doc/BRIEF.md
# Serial Flash Controller

This block is a register-mapped peripheral that runs single-lane SPI transactions against a serial flash device for a host processor. The host loads an instruction value, an address value, a header byte-count register and a data byte count. It then sets a start handshake bit together with a direction bit. The block shifts out the header bytes: first the instruction bytes, then the address bytes. After that it moves data bytes between the SPI pins and two 8-entry FIFOs. The write FIFO is filled through one register and the read FIFO is drained through another.

Chip select is driven straight from a writable control bit. A ready flag shows when the pin has settled after a change. The start, stop and flush bits are handshakes that clear themselves. A read with a data count of zero keeps clocking bytes until the host asks it to stop. While the read FIFO is full, the serial clock pauses.

Top module: `serial_flash_ctrl`

## Requirements
- R1: After reset the control register (offset 0x00) reads 0x52, which means ready, read-FIFO-empty and write-FIFO-empty are set. The config register (offset 0x04) reads 0. spiCsN is high and spiSclk is low.
- R2: Control bit 0 is the only writable control bit, and spiCsN always equals its inverse. Ready (bit 1) drops in the cycle after the pin changes and returns after CS_SETTLE cycles. Read-FIFO-empty is bit 4, write-FIFO-empty is bit 6 and write-FIFO-full is bit 7.
- R3: The SPI link runs in mode 0. spiSclk idles low, bytes go out MSB first, spiMosi changes only after a falling edge and spiMiso is sampled on the rising edge. Each clock phase lasts CLK_HALF system cycles.
- R4: Writing config bit 15 starts a transfer. The block first sends N instruction bytes, where N is bits 3:0 of the header register (0x1C). It then sends M address bytes, where M is bits 7:4. Both groups come from the 32-bit instruction (0x10) and address (0x14) registers and are sent most significant byte first. Any byte position of 4 or more sends 0x00. For example, 0x31 gives one instruction byte and three address bytes.
- R5: With config bit 13 = 1 (write), the data phase sends the write-FIFO bytes in the order they were pushed. Writing offset 0x08 pushes bits 7:0 into the FIFO. A push while the FIFO holds 8 entries is dropped.
- R6: With config bit 13 = 0 (read), each data byte drives 0x00 on spiMosi and stores the received byte in the read FIFO. Reading offset 0x0C returns the oldest byte in bits 7:0 and pops it.
- R7: A nonzero data count (offset 0x20) stops the read clocking after exactly that many data bytes.
- R8: A data count of 0 makes the read continuous. The serial clock pauses while the read FIFO holds 8 bytes and resumes after a pop.
- R9: Config bit 14 (stop) ends the transfer once the write FIFO is empty and no byte is in flight. Start reads 1 until that point, and then start and stop both clear themselves.
- R10: Config bit 9 (flush) empties both FIFOs. It reads 1 for one cycle after the write and then clears itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 6 | Register byte offset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (pops on the data-in offset) |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational from regAddr |
| spiSclk | output | 1 | Serial clock |
| spiCsN | output | 1 | Chip select, active low |
| spiMosi | output | 1 | Serial data to the flash |
| spiMiso | input | 1 | Serial data from the flash |

## Verification
The hardest condition to reach from the ports is the read stall. The read FIFO has to fill completely while the sequencer keeps wanting more bytes, and then pops must release the clock one byte at a time. The bench starts an endless read and leaves the FIFO undrained long enough for the clock to freeze. It counts the bytes the slave model has seen, then pops two bytes with long gaps between them and checks that exactly one extra byte is clocked per pop. A drain after stop then confirms that the FIFO order survived the stall.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  // register offsets
  localparam logic [5:0] OFS_CTRL  = 6'h00;
  localparam logic [5:0] OFS_CONF  = 6'h04;
  localparam logic [5:0] OFS_DOUT  = 6'h08;
  localparam logic [5:0] OFS_DIN   = 6'h0C;
  localparam logic [5:0] OFS_INSTR = 6'h10;
  localparam logic [5:0] OFS_ADDR  = 6'h14;
  localparam logic [5:0] OFS_RMODE = 6'h18;
  localparam logic [5:0] OFS_HDR   = 6'h1C;
  localparam logic [5:0] OFS_DCNT  = 6'h20;

  // control register bits
  localparam int CTL_CS     = 0;
  localparam int CTL_RDY    = 1;
  localparam int CTL_REMPTY = 4;
  localparam int CTL_WEMPTY = 6;
  localparam int CTL_WFULL  = 7;

  // config register bits
  localparam int CFG_FLUSH = 9;
  localparam int CFG_LANE  = 10;
  localparam int CFG_DIR   = 13;
  localparam int CFG_STOP  = 14;
  localparam int CFG_START = 15;

  typedef enum logic [1:0] {SRC_ZERO, SRC_INSTR, SRC_ADDR, SRC_WFIFO} byteSrc_e;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic     shiftGo;
    byteSrc_e src;
    logic [3:0] hdrIdx;
    logic     popWr;
    logic     pushRd;
    logic     xferEnd;
  } seqStrobe_t;
endpackage

// File: rtl/sfc_fifo.sv
module sfc_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wPtr, rPtr;
  logic [CW-1:0] count;
  logic pushOk, popOk;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign pushOk  = push && !full;
  assign popOk   = pop && !empty;
  assign popData = mem[rPtr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (pushOk && !clr) mem[wPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wPtr <= '0; rPtr <= '0; count <= '0;
    end else if (clr) begin
      wPtr <= '0; rPtr <= '0; count <= '0;
    end else begin
      if (pushOk) wPtr <= bump(wPtr);
      if (popOk)  rPtr <= bump(rPtr);
      count <= count + CW'(pushOk) - CW'(popOk);
    end
  end

  // R5: a push into a full FIFO leaves the level untouched
  a_r5_full_push_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop && !clr) |=> (count == $past(count)));
endmodule

// File: rtl/sfc_datapath.sv
module sfc_datapath
  import sfc_pkg::*;
#(
  parameter int CLK_HALF   = 2,
  parameter int CS_SETTLE  = 4,
  parameter int FIFO_DEPTH = 8,
  parameter int DCNT_W     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [5:0]        regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  seqStrobe_t        strobe,
  output logic              startReq,
  output logic              stopReq,
  output logic              dirWrite,
  output logic [3:0]        instrCnt,
  output logic [3:0]        addrCnt,
  output logic [DCNT_W-1:0] dataCnt,
  output logic              shiftBusy,
  output logic              shiftDone,
  output logic              wEmpty,
  output logic              rFull,
  output logic              spiSclk,
  output logic              spiCsN,
  output logic              spiMosi,
  input  logic              spiMiso
);
  localparam int DIV_W = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
  localparam int SET_W = $clog2(CS_SETTLE + 1);

  logic csEn, flushBit, dirBit, stopBit, startBit;
  logic [2:0] laneSel;
  logic [SET_W-1:0] settleCnt;
  logic xferReady;
  logic [31:0] instrReg, addrReg;
  logic [7:0] rmodeReg, hdrReg;
  logic [DCNT_W-1:0] dcntReg;
  logic wFull, rEmpty;
  logic [7:0] wHead, rHead, txByte;
  logic [7:0] txSh, rxSh;
  logic [2:0] bitCnt;
  logic [DIV_W-1:0] divCnt;
  logic sclkR;
  logic hitConf, hitCtrl, popIn;

  assign hitConf   = regWr && (regAddr == OFS_CONF);
  assign hitCtrl   = regWr && (regAddr == OFS_CTRL);
  assign popIn     = regRd && (regAddr == OFS_DIN);
  assign xferReady = (settleCnt == '0);
  assign startReq  = startBit;
  assign stopReq   = stopBit;
  assign dirWrite  = dirBit;
  assign instrCnt  = hdrReg[3:0];
  assign addrCnt   = hdrReg[7:4];
  assign dataCnt   = dcntReg;
  assign spiCsN    = ~csEn;
  assign spiSclk   = sclkR;
  assign spiMosi   = shiftBusy ? txSh[7] : 1'b0;

  // chip select and settle timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csEn <= 1'b0; settleCnt <= '0;
    end else if (hitCtrl && (regWdata[CTL_CS] != csEn)) begin
      csEn <= regWdata[CTL_CS];
      settleCnt <= SET_W'(CS_SETTLE);
    end else if (settleCnt != '0) begin
      settleCnt <= settleCnt - 1'b1;
    end
  end

  // config handshakes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flushBit <= 1'b0; dirBit <= 1'b0; stopBit <= 1'b0;
      startBit <= 1'b0; laneSel <= '0;
    end else begin
      if (flushBit) flushBit <= 1'b0;
      if (strobe.xferEnd) begin
        startBit <= 1'b0; stopBit <= 1'b0;
      end
      if (hitConf) begin
        if (regWdata[CFG_FLUSH]) flushBit <= 1'b1;
        if (!startBit) begin
          laneSel <= regWdata[CFG_LANE +: 3];
          dirBit  <= regWdata[CFG_DIR];
          if (regWdata[CFG_START]) startBit <= 1'b1;
        end
        if (regWdata[CFG_STOP] &&
            ((startBit && !strobe.xferEnd) || (!startBit && regWdata[CFG_START])))
          stopBit <= 1'b1;
      end
    end
  end

  // plain storage registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      instrReg <= '0; addrReg <= '0; rmodeReg <= '0; hdrReg <= '0; dcntReg <= '0;
    end else if (regWr) begin
      case (regAddr)
        OFS_INSTR: instrReg <= regWdata;
        OFS_ADDR:  addrReg  <= regWdata;
        OFS_RMODE: rmodeReg <= regWdata[7:0];
        OFS_HDR:   hdrReg   <= regWdata[7:0];
        OFS_DCNT:  dcntReg  <= regWdata[DCNT_W-1:0];
        default: ;
      endcase
    end
  end

  sfc_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) uWrFifo (
    .clk(clk), .rstN(rstN), .clr(flushBit),
    .push(regWr && (regAddr == OFS_DOUT)), .pushData(regWdata[7:0]),
    .pop(strobe.popWr), .popData(wHead), .empty(wEmpty), .full(wFull));

  sfc_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) uRdFifo (
    .clk(clk), .rstN(rstN), .clr(flushBit),
    .push(strobe.pushRd), .pushData(rxSh),
    .pop(popIn), .popData(rHead), .empty(rEmpty), .full(rFull));

  function automatic logic [7:0] pickByte(input logic [31:0] w, input logic [3:0] idx);
    return (idx[3:2] != 2'b00) ? 8'h00 : w[8*idx[1:0] +: 8];
  endfunction

  always_comb begin
    case (strobe.src)
      SRC_INSTR: txByte = pickByte(instrReg, strobe.hdrIdx);
      SRC_ADDR:  txByte = pickByte(addrReg, strobe.hdrIdx);
      SRC_WFIFO: txByte = wHead;
      default:   txByte = 8'h00;
    endcase
  end

  // mode-0 byte shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh <= '0; rxSh <= '0; bitCnt <= '0; divCnt <= '0;
      sclkR <= 1'b0; shiftBusy <= 1'b0; shiftDone <= 1'b0;
    end else begin
      shiftDone <= 1'b0;
      if (!shiftBusy) begin
        if (strobe.shiftGo) begin
          txSh <= txByte; bitCnt <= '0; divCnt <= '0;
          sclkR <= 1'b0; shiftBusy <= 1'b1;
        end
      end else if (divCnt == DIV_W'(CLK_HALF - 1)) begin
        divCnt <= '0;
        if (!sclkR) begin
          sclkR <= 1'b1;
          rxSh  <= {rxSh[6:0], spiMiso};
        end else begin
          sclkR <= 1'b0;
          if (bitCnt == 3'd7) begin
            shiftBusy <= 1'b0; shiftDone <= 1'b1;
          end else begin
            bitCnt <= bitCnt + 1'b1;
            txSh   <= {txSh[6:0], 1'b0};
          end
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      OFS_CTRL: begin
        regRdata[CTL_CS]     = csEn;
        regRdata[CTL_RDY]    = xferReady;
        regRdata[CTL_REMPTY] = rEmpty;
        regRdata[CTL_WEMPTY] = wEmpty;
        regRdata[CTL_WFULL]  = wFull;
      end
      OFS_CONF: begin
        regRdata[CFG_FLUSH]      = flushBit;
        regRdata[CFG_LANE +: 3]  = laneSel;
        regRdata[CFG_DIR]        = dirBit;
        regRdata[CFG_STOP]       = stopBit;
        regRdata[CFG_START]      = startBit;
      end
      OFS_DIN:   regRdata[7:0] = rHead;
      OFS_INSTR: regRdata = instrReg;
      OFS_ADDR:  regRdata = addrReg;
      OFS_RMODE: regRdata[7:0] = rmodeReg;
      OFS_HDR:   regRdata[7:0] = hdrReg;
      OFS_DCNT:  regRdata[DCNT_W-1:0] = dcntReg;
      default: ;
    endcase
  end

  // R2: a chip-select change always drops ready
  a_r2_cs_change_unready: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(spiCsN) |-> !xferReady);
  // R3: serial clock moves only while a byte is in flight
  a_r3_sclk_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(spiSclk) |-> $past(shiftBusy));
  // R3: the sequencer never loads the shifter mid-byte
  a_r3_no_load_midbyte: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftGo |-> !shiftBusy);
  // R8: read FIFO is never pushed while full
  a_r8_rfifo_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pushRd |-> !rFull);
  // R9: start only falls after a stop request
  a_r9_start_needs_stop: assert property (@(posedge clk) disable iff (!rstN)
    $fell(startBit) |-> $past(stopBit));
  // R10: flush leaves both FIFOs empty
  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    flushBit |=> (wEmpty && rEmpty));
endmodule

// File: rtl/sfc_control.sv
module sfc_control
  import sfc_pkg::*;
#(
  parameter int DCNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              stopReq,
  input  logic              dirWrite,
  input  logic [3:0]        instrCnt,
  input  logic [3:0]        addrCnt,
  input  logic [DCNT_W-1:0] dataCnt,
  input  logic              shiftBusy,
  input  logic              shiftDone,
  input  logic              wEmpty,
  input  logic              rFull,
  output seqStrobe_t        strobe
);
  typedef enum logic [2:0] {S_IDLE, S_INSTR, S_ADDR, S_DATA, S_HOLD, S_END} seqState_e;

  seqState_e state;
  logic [3:0] remain;
  logic [DCNT_W-1:0] left;
  logic endless;
  logic engineFree;

  assign engineFree = !shiftBusy && !shiftDone;

  always_comb begin
    strobe = '0;
    strobe.pushRd = shiftDone && (state == S_DATA) && !dirWrite;
    case (state)
      S_INSTR: if (remain != 4'd0 && engineFree) begin
        strobe.shiftGo = 1'b1; strobe.src = SRC_INSTR; strobe.hdrIdx = remain - 4'd1;
      end
      S_ADDR: if (remain != 4'd0 && engineFree) begin
        strobe.shiftGo = 1'b1; strobe.src = SRC_ADDR; strobe.hdrIdx = remain - 4'd1;
      end
      S_DATA: if (engineFree) begin
        if (dirWrite) begin
          if (!wEmpty) begin
            strobe.shiftGo = 1'b1; strobe.src = SRC_WFIFO; strobe.popWr = 1'b1;
          end
        end else if (!stopReq && !rFull && (endless || left != '0)) begin
          strobe.shiftGo = 1'b1; strobe.src = SRC_ZERO;
        end
      end
      S_END: strobe.xferEnd = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; remain <= '0; left <= '0; endless <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (startReq) begin
          remain <= instrCnt; state <= S_INSTR;
        end
        S_INSTR: if (strobe.shiftGo) remain <= remain - 4'd1;
          else if (remain == 4'd0 && engineFree) begin
            remain <= addrCnt; state <= S_ADDR;
          end
        S_ADDR: if (strobe.shiftGo) remain <= remain - 4'd1;
          else if (remain == 4'd0 && engineFree) begin
            left <= dataCnt; endless <= (dataCnt == '0); state <= S_DATA;
          end
        S_DATA: if (strobe.shiftGo) begin
            if (!dirWrite && !endless) left <= left - 1'b1;
          end else if (engineFree && stopReq && (wEmpty || !dirWrite)) state <= S_END;
          else if (engineFree && !dirWrite && !endless && left == '0) state <= S_HOLD;
        S_HOLD: if (stopReq) state <= S_END;
        S_END:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7: a finished counted read keeps the shifter quiet
  a_r7_hold_is_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HOLD) |-> !shiftBusy);
  // R9: a transfer only ends with the shifter idle
  a_r9_end_idle: assert property (@(posedge clk) disable iff (!rstN)
    strobe.xferEnd |-> (!shiftBusy && stopReq));
endmodule

// File: rtl/serial_flash_ctrl.sv
module serial_flash_ctrl
  import sfc_pkg::*;
#(
  parameter int CLK_HALF   = 2,
  parameter int CS_SETTLE  = 4,
  parameter int FIFO_DEPTH = 8,
  parameter int DCNT_W     = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [5:0]  regAddr,
  input  logic        regWr,
  input  logic        regRd,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        spiSclk,
  output logic        spiCsN,
  output logic        spiMosi,
  input  logic        spiMiso
);
  seqStrobe_t strobe;
  logic startReq, stopReq, dirWrite, shiftBusy, shiftDone, wEmpty, rFull;
  logic [3:0] instrCnt, addrCnt;
  logic [DCNT_W-1:0] dataCnt;

  sfc_datapath #(.CLK_HALF(CLK_HALF), .CS_SETTLE(CS_SETTLE),
                 .FIFO_DEPTH(FIFO_DEPTH), .DCNT_W(DCNT_W)) uData (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .strobe(strobe),
    .startReq(startReq), .stopReq(stopReq), .dirWrite(dirWrite),
    .instrCnt(instrCnt), .addrCnt(addrCnt), .dataCnt(dataCnt),
    .shiftBusy(shiftBusy), .shiftDone(shiftDone), .wEmpty(wEmpty), .rFull(rFull),
    .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMosi(spiMosi), .spiMiso(spiMiso));

  sfc_control #(.DCNT_W(DCNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .stopReq(stopReq),
    .dirWrite(dirWrite), .instrCnt(instrCnt), .addrCnt(addrCnt), .dataCnt(dataCnt),
    .shiftBusy(shiftBusy), .shiftDone(shiftDone), .wEmpty(wEmpty), .rFull(rFull),
    .strobe(strobe));
endmodule

// File: tb/serial_flash_ctrl_test.sv
module serial_flash_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HALF   = 2;
  localparam int CS_SETTLE  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [5:0] regAddr = '0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic spiSclk, spiCsN, spiMosi, spiMiso;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  serial_flash_ctrl #(.CLK_HALF(CLK_HALF), .CS_SETTLE(CS_SETTLE)) uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .spiSclk(spiSclk), .spiCsN(spiCsN),
    .spiMosi(spiMosi), .spiMiso(spiMiso));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] resp(int k);
    return 8'((k * 29 + 59) & 255);
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard queues for serial output
  logic [7:0] expMosi[$];
  string expTag[$];
  task automatic expectByte(logic [7:0] b, string tag);
    expMosi.push_back(b); expTag.push_back(tag);
  endtask

  // slave model and monitor
  logic [7:0] sOut = 8'h00, sIn = 8'h00;
  int sBit = 0, sIdx = 0, slaveBytes = 0;
  time tRise = 0;
  bit measured = 0;
  assign spiMiso = sOut[7];

  always @(negedge spiCsN) begin
    sIdx = 0; sBit = 0; sOut = resp(0);
  end
  always @(posedge spiSclk) begin
    tRise = $time;
    sIn = {sIn[6:0], spiMosi};
    sBit++;
    if (sBit == 8) begin
      sBit = 0; sIdx++; slaveBytes++;
      if (expMosi.size() == 0) begin
        nChecks++; nFails++;
        $display("FAIL R5: unexpected serial byte actual 0x%0h expected none", sIn);
      end else begin
        logic [7:0] e; string t;
        e = expMosi.pop_front(); t = expTag.pop_front();
        check(sIn == e, t, sIn, e);
      end
    end
  end
  always @(negedge spiSclk) begin
    if (!measured) begin
      measured = 1;
      check(($time - tRise) == CLK_HALF * CLK_PERIOD, "R3 high phase width",
            $time - tRise, CLK_HALF * CLK_PERIOD);
    end
    if (sBit == 0) sOut = resp(sIdx);
    else sOut = {sOut[6:0], 1'b0};
  end

  // bus tasks, called at a falling clock edge
  task automatic wr(logic [5:0] a, logic [31:0] d);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask
  task automatic rd(logic [5:0] a, output logic [31:0] d);
    regAddr = a; regRd = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask
  task automatic waitStartClear(string tag);
    logic [31:0] v;
    for (int i = 0; i < 5000; i++) begin
      rd(6'h04, v);
      if (!v[15]) break;
    end
    check(v[15] == 1'b0, tag, v[15], 0);
  endtask
  task automatic csCycle();
    wr(6'h00, 0); repeat (CS_SETTLE + 2) @(negedge clk);
    wr(6'h00, 1); repeat (CS_SETTLE + 2) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(6'h00, v); check(v == 32'h52, "R1 control reset", v, 32'h52);
    rd(6'h04, v); check(v == 0, "R1 config reset", v, 0);
    check(spiCsN == 1'b1 && spiSclk == 1'b0, "R1 pins reset", {spiCsN, spiSclk}, 2'b10);

    // R2 chip select and ready
    wr(6'h00, 32'hFFFF_FFFF);
    rd(6'h00, v);
    check(spiCsN == 1'b0, "R2 csN low", spiCsN, 0);
    check(v[1] == 1'b0 && v[0] == 1'b1, "R2 ready dropped", v[1:0], 2'b01);
    check(v[31:8] == 0, "R2 only bit0 writable", v[31:8], 0);
    repeat (CS_SETTLE + 1) @(negedge clk);
    rd(6'h00, v); check(v[1] == 1'b1, "R2 ready back", v[1], 1);

    // R5 + R9 write transfer, FIFO overfill, stop while data pending
    csCycle();
    for (int i = 0; i < 10; i++) wr(6'h08, 32'hC0 + i);
    rd(6'h00, v); check(v[7] == 1 && v[6] == 0, "R2 wfull status bit7", v[7:6], 2'b10);
    wr(6'h1C, 32'h31); wr(6'h10, 32'h02); wr(6'h14, 32'h00AB_CDEF);
    expectByte(8'h02, "R4 instr"); expectByte(8'hAB, "R4 addr2");
    expectByte(8'hCD, "R4 addr1"); expectByte(8'hEF, "R4 addr0");
    for (int i = 0; i < 8; i++) expectByte(8'(8'hC0 + i), "R5 write data");
    wr(6'h04, (1 << 13) | (1 << 15));
    wr(6'h04, (1 << 13) | (1 << 14));
    rd(6'h04, v); check(v[15] == 1'b1, "R9 start held while draining", v[15], 1);
    waitStartClear("R9 start self-clears");
    rd(6'h04, v); check(v[14] == 1'b0, "R9 stop self-clears", v[14], 0);
    rd(6'h00, v); check(v[6] == 1'b1, "R5 wfifo drained", v[6], 1);

    // R6 + R7 counted read
    csCycle();
    wr(6'h1C, 32'h31); wr(6'h10, 32'h03); wr(6'h14, 32'h0000_0100); wr(6'h20, 5);
    expectByte(8'h03, "R4 read instr"); expectByte(8'h00, "R4 read a2");
    expectByte(8'h01, "R4 read a1");    expectByte(8'h00, "R4 read a0");
    for (int i = 0; i < 5; i++) expectByte(8'h00, "R6 read drives zero");
    slaveBytes = 0;
    wr(6'h04, 1 << 15);
    repeat (600) @(negedge clk);
    check(slaveBytes == 9, "R7 exact byte count", slaveBytes, 9);
    for (int i = 0; i < 3; i++) begin
      rd(6'h0C, v); check(v[7:0] == resp(4 + i), "R6 read data", v[7:0], resp(4 + i));
    end
    rd(6'h00, v); check(v[4] == 1'b0, "R6 rfifo still holds", v[4], 0);
    repeat (300) @(negedge clk);
    check(slaveBytes == 9, "R7 no extra clocking", slaveBytes, 9);
    wr(6'h04, 1 << 14);
    waitStartClear("R9 read stop");

    // R10 flush both FIFOs
    for (int i = 0; i < 3; i++) wr(6'h08, 32'h55);
    wr(6'h04, 1 << 9);
    rd(6'h04, v); check(v[9] == 1'b1, "R10 flush visible", v[9], 1);
    rd(6'h04, v); check(v[9] == 1'b0, "R10 flush self-clears", v[9], 0);
    rd(6'h00, v); check(v[6] == 1'b1 && v[4] == 1'b1, "R10 both empty", {v[6], v[4]}, 2'b11);

    // R4 dummy header bytes, two instruction bytes
    csCycle();
    wr(6'h1C, 32'h52); wr(6'h10, 32'h0000_9A3B); wr(6'h14, 32'h1122_3344);
    expectByte(8'h9A, "R4 instr hi"); expectByte(8'h3B, "R4 instr lo");
    expectByte(8'h00, "R4 dummy"); expectByte(8'h11, "R4 a3");
    expectByte(8'h22, "R4 a2"); expectByte(8'h33, "R4 a1"); expectByte(8'h44, "R4 a0");
    wr(6'h04, (1 << 13) | (1 << 14) | (1 << 15));
    waitStartClear("R9 header-only end");

    // R4 no instruction bytes, R7 count of one
    csCycle();
    wr(6'h1C, 32'h20); wr(6'h20, 1);
    expectByte(8'h33, "R4 addr only a1"); expectByte(8'h44, "R4 addr only a0");
    expectByte(8'h00, "R6 single read");
    wr(6'h04, 1 << 15);
    repeat (300) @(negedge clk);
    rd(6'h0C, v); check(v[7:0] == resp(2), "R7 single byte", v[7:0], resp(2));
    wr(6'h04, 1 << 14);
    waitStartClear("R9 single end");

    // R8 endless read with FIFO stall
    csCycle();
    wr(6'h1C, 32'h01); wr(6'h10, 32'h05); wr(6'h20, 0);
    expectByte(8'h05, "R8 status instr");
    for (int i = 0; i < 10; i++) expectByte(8'h00, "R8 endless read");
    slaveBytes = 0;
    wr(6'h04, 1 << 15);
    repeat (2000) @(negedge clk);
    check(slaveBytes == 9, "R8 stall at full", slaveBytes, 9);
    for (int i = 0; i < 2; i++) begin
      rd(6'h0C, v); check(v[7:0] == resp(1 + i), "R8 popped data", v[7:0], resp(1 + i));
      repeat (200) @(negedge clk);
    end
    check(slaveBytes == 11, "R8 one byte per pop", slaveBytes, 11);
    wr(6'h04, 1 << 14);
    waitStartClear("R9 endless stop");
    for (int i = 0; i < 8; i++) begin
      rd(6'h0C, v); check(v[7:0] == resp(3 + i), "R8 drain order", v[7:0], resp(3 + i));
    end
    rd(6'h00, v); check(v[4] == 1'b1, "R6 rfifo empty after drain", v[4], 1);
    check(expMosi.size() == 0, "R4 all serial bytes seen", expMosi.size(), 0);

    finishRun();
  end
endmodule